// File: doc/BRIEF.md
# Prefetching Bus Cycle Sequencer

This block sequences the bus of a small 16-bit processor. A two-bit phase steps through T1, T2, T3 and T4 once per clock. On each cycle the block chooses between filling the instruction byte queue and serving a data request from the execution side. A data request can be a memory read or write, an I/O read or write, or an interrupt acknowledge. The data transfer or queue push itself happens in T3. The block decides whether to start the next instruction fetch only in T3, using the prefetch enable and the queue fill level.

When a data request arrives while an instruction fetch is scheduled, the fetch is dropped. The cost of dropping it depends on how far the fetch has gone. A queue flush returns the sequencer to T1 and cancels the scheduled fetch. A flush with suspend also adds three idle clocks. While the bus is active, a low ready input stretches the current phase.

The requester holds the request word steady until it sees the transfer strobe. It removes the request in the clock after the strobe. A request that is still held after the strobe starts another access.

Top module: `bus_seq`

## Requirements
- R1: While reset is low and on the first clock after it, the phase is T1 (0), a fetch is scheduled, there is no transfer strobe, the code indicator is 0 and the passive flag is 0.
- R2: Outside idle clocks, flushes and ready stalls, the phase advances 0→1→2→3→0 on every clock. This holds even when the bus has no work.
- R3: A transfer strobe occurs only in T3 (2) of an active bus cycle. Its type is the data request word, or 8 (bit 3, code fetch) when the cycle is a prefetch. In an active T1 the code indicator is loaded with 1 for a prefetch and 0 for a data access.
- R4: At every T3 that is not stalled, the fetch-scheduled state is reloaded with (prefetch enable and fill level < QDEPTH).
- R5: A data request is present when request bit 4 (I/O), bit 5 (memory) or bit 6 (acknowledge) is set. It arrives on the first clock it is present after a clock without one. An arrival in T1 or T2 while a fetch is scheduled cancels the fetch at no cost, and that clock acts as T1 of the data access.
- R6: An arrival in T3 or T4 while a fetch is scheduled cancels the fetch and costs 5 − phase idle clocks (3 from T3, 2 from T4), counting the arrival clock. During these clocks the phase is held at T1. The data access then starts at T1.
- R7: While the bus is active (a data request is present or a fetch is scheduled), a low ready input holds the phase and suppresses the strobe. Ready is ignored when the bus is not active.
- R8: The passive flag is high exactly when no data request is present and the sequencer is not in T1 with a fetch scheduled.
- R9: A flush takes priority over everything else. It sets the phase to T1 and cancels the scheduled fetch on the next clock. With suspend high it also inserts three idle clocks with no strobe.
- R10: A data request that arrives with no fetch scheduled runs from the current phase without any penalty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 7 | Request word: bit0 out, bit1 high byte, bit2 wide, bit3 code, bit4 I/O, bit5 memory, bit6 acknowledge |
| q_level_i | input | LVL_W | Queue fill level in bytes |
| pf_en_i | input | 1 | Prefetch enable |
| flush_i | input | 1 | Queue flush strobe |
| suspend_i | input | 1 | With flush: add three idle clocks |
| rdy_i | input | 1 | Bus ready; low inserts wait clocks |
| phase_o | output | 2 | Current bus phase (0 = T1 .. 3 = T4) |
| xfer_o | output | 1 | Transfer strobe in T3 |
| xfer_type_o | output | 7 | Access type of the strobed transfer |
| code_o | output | 1 | Code/data indicator latched at T1 |
| passive_o | output | 1 | Bus passive flag |

## Verification
The bench sends data requests at each of the four phases while a fetch is scheduled. If a design charged the abort penalty at T1/T2, or used the wrong idle count at T3/T4, its strobes would come on the wrong clock. Ready is pulled low both with the bus active and with it empty. A design that stalls while empty, or ignores the stall while active, would lose phase alignment. The bench also fills the queue, drops prefetch enable and issues flushes with and without suspend. These checks catch a schedule that is updated outside T3, a flush that does not return to T1, and a missing run of suspend idle clocks.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  localparam int REQ_W   = 7;
  localparam int B_OUT   = 0;
  localparam int B_HIGH  = 1;
  localparam int B_WIDE  = 2;
  localparam int B_CODE  = 3;
  localparam int B_IO    = 4;
  localparam int B_MEM   = 5;
  localparam int B_ACK   = 6;

  typedef enum logic [1:0] {PH_T1 = 2'd0, PH_T2 = 2'd1, PH_T3 = 2'd2, PH_T4 = 2'd3} phase_e;

  function automatic logic is_data(input logic [REQ_W-1:0] r);
    return r[B_IO] | r[B_MEM] | r[B_ACK];
  endfunction
endpackage

// File: rtl/bus_seq_idle.sv
module bus_seq_idle #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         busy_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/bus_seq_phase.sv
module bus_seq_phase
  import bus_seq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clear_i,
  input  logic   hold_i,
  input  phase_e base_i,
  output phase_e phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_o <= PH_T1;
    else if (clear_i) phase_o <= PH_T1;
    else if (hold_i)  phase_o <= base_i;
    else              phase_o <= phase_e'(base_i + 2'd1);
  end
endmodule

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
  import bus_seq_pkg::*;
#(
  parameter int IDLE_W = 3
) (
  input  phase_e            phase_i,
  input  logic              sched_i,
  input  logic              idle_busy_i,
  input  logic              data_i,
  input  logic              arrive_i,
  input  logic              flush_i,
  input  logic              suspend_i,
  input  logic              rdy_i,
  output phase_e            eff_phase_o,
  output logic              ph_clear_o,
  output logic              ph_hold_o,
  output logic              idle_load_o,
  output logic [IDLE_W-1:0] idle_val_o,
  output logic              sched_clr_o,
  output logic              sched_eval_o,
  output logic              xfer_o,
  output logic              latch_code_o
);
  localparam logic [IDLE_W-1:0] SUSP_IDLE = IDLE_W'(3);

  logic late_abort, early_cancel, active;

  assign late_abort   = arrive_i & sched_i & phase_i[1];
  assign early_cancel = arrive_i & sched_i & ~phase_i[1];

  always_comb begin
    eff_phase_o  = phase_i;
    ph_clear_o   = 1'b0;
    ph_hold_o    = 1'b0;
    idle_load_o  = 1'b0;
    idle_val_o   = '0;
    sched_clr_o  = 1'b0;
    sched_eval_o = 1'b0;
    xfer_o       = 1'b0;
    latch_code_o = 1'b0;
    active       = 1'b0;
    if (flush_i) begin
      ph_clear_o  = 1'b1;
      sched_clr_o = 1'b1;
      idle_load_o = suspend_i;
      idle_val_o  = SUSP_IDLE;
    end else if (idle_busy_i) begin
      ph_hold_o = 1'b1;
    end else if (late_abort) begin
      // arrival clock counts as first idle clock: 3 at T3, 2 at T4
      ph_clear_o  = 1'b1;
      sched_clr_o = 1'b1;
      idle_load_o = 1'b1;
      idle_val_o  = IDLE_W'(3'd4 - {1'b0, phase_i});
    end else begin
      if (early_cancel) begin
        eff_phase_o = PH_T1;
        sched_clr_o = 1'b1;
      end
      active = data_i | (sched_i & ~early_cancel);
      if (active && !rdy_i) begin
        ph_hold_o = 1'b1;
      end else begin
        latch_code_o = active && (eff_phase_o == PH_T1);
        xfer_o       = active && (eff_phase_o == PH_T3);
        sched_eval_o = (eff_phase_o == PH_T3);
      end
    end
  end
endmodule

// File: rtl/bus_seq.sv
module bus_seq
  import bus_seq_pkg::*;
#(
  parameter int QDEPTH = 6,
  parameter int IDLE_W = 3,
  parameter int LVL_W  = $clog2(QDEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REQ_W-1:0] req_i,
  input  logic [LVL_W-1:0] q_level_i,
  input  logic             pf_en_i,
  input  logic             flush_i,
  input  logic             suspend_i,
  input  logic             rdy_i,
  output logic [1:0]       phase_o,
  output logic             xfer_o,
  output logic [REQ_W-1:0] xfer_type_o,
  output logic             code_o,
  output logic             passive_o
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(QDEPTH);
  localparam logic [REQ_W-1:0] CODE_T   = REQ_W'(1) << B_CODE;

  phase_e            phase_q, eff_phase;
  logic              sched_q, req_prev_q, code_q;
  logic              data_req, arrive, idle_busy;
  logic              ph_clear, ph_hold, idle_load, sched_clr, sched_eval, xfer, latch_code;
  logic [IDLE_W-1:0] idle_val;

  assign data_req = is_data(req_i);
  assign arrive   = data_req & ~req_prev_q;

  bus_seq_ctrl #(.IDLE_W(IDLE_W)) u_ctrl (
    .phase_i     (phase_q),
    .sched_i     (sched_q),
    .idle_busy_i (idle_busy),
    .data_i      (data_req),
    .arrive_i    (arrive),
    .flush_i     (flush_i),
    .suspend_i   (suspend_i),
    .rdy_i       (rdy_i),
    .eff_phase_o (eff_phase),
    .ph_clear_o  (ph_clear),
    .ph_hold_o   (ph_hold),
    .idle_load_o (idle_load),
    .idle_val_o  (idle_val),
    .sched_clr_o (sched_clr),
    .sched_eval_o(sched_eval),
    .xfer_o      (xfer),
    .latch_code_o(latch_code)
  );

  bus_seq_phase u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(ph_clear),
    .hold_i (ph_hold),
    .base_i (eff_phase),
    .phase_o(phase_q)
  );

  bus_seq_idle #(.W(IDLE_W)) u_idle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(idle_load),
    .val_i (idle_val),
    .busy_o(idle_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sched_q    <= 1'b1;
      req_prev_q <= 1'b0;
      code_q     <= 1'b0;
    end else begin
      req_prev_q <= data_req;
      if (sched_eval)      sched_q <= pf_en_i & (q_level_i < FULL_LVL);
      else if (sched_clr)  sched_q <= 1'b0;
      if (latch_code)      code_q  <= ~data_req;
    end
  end

  assign phase_o     = eff_phase;
  assign xfer_o      = xfer;
  assign xfer_type_o = !xfer ? '0 : (data_req ? req_i : CODE_T);
  assign code_o      = code_q;
  assign passive_o   = ~data_req & ~((phase_q == PH_T1) & sched_q);
endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [6:0] req_i,
  input logic       flush_i,
  input logic       suspend_i,
  input logic       rdy_i,
  input logic [1:0] phase_o,
  input logic       xfer_o,
  input logic [6:0] xfer_type_o
);
  // R3
  strobe_in_t3_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> phase_o == 2'd2);
  // R3
  code_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && req_i[6:4] == 3'b000) |-> xfer_type_o == 7'd8);
  // R5
  one_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> $onehot0({xfer_type_o[6:3]}));
  // R7
  stall_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdy_i |-> !xfer_o);
  // R9
  flush_t1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> phase_o == 2'd0);
  // R9
  suspend_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && suspend_i) |=> !xfer_o);
endmodule

bind bus_seq bus_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .flush_i    (flush_i),
  .suspend_i  (suspend_i),
  .rdy_i      (rdy_i),
  .phase_o    (phase_o),
  .xfer_o     (xfer_o),
  .xfer_type_o(xfer_type_o)
);

// File: tb/bus_seq_bench.sv
module bus_seq_bench;
  localparam int QDEPTH = 6;
  localparam int LVL_W  = $clog2(QDEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] req = '0;
  logic [LVL_W-1:0] lvl = '0;
  logic pf_en = 1'b1, flush = 1'b0, susp = 1'b0, rdy = 1'b1;
  logic [1:0] phase;
  logic xfer, code, passive;
  logic [6:0] xtype;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  int m_ph, m_sc, m_idl, m_prev, m_code;
  int e_ph, e_x, e_t, e_pas;

  always #10 clk = ~clk;

  bus_seq #(.QDEPTH(QDEPTH)) u_bus_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .q_level_i(lvl), .pf_en_i(pf_en),
    .flush_i(flush), .suspend_i(susp), .rdy_i(rdy), .phase_o(phase), .xfer_o(xfer),
    .xfer_type_o(xtype), .code_o(code), .passive_o(passive)
  );

  function automatic int has_data(input logic [6:0] r);
    return (r[6:4] != 3'b000) ? 1 : 0;
  endfunction

  task automatic model_reset();
    m_ph = 0; m_sc = 1; m_idl = 0; m_prev = 0; m_code = 0;
  endtask

  // computes expected outputs and advances the model by one clock
  task automatic model_clock();
    int d, arr, cancel, act, n_ph, n_sc, n_idl, n_code;
    d = has_data(req);
    arr = d && !m_prev;
    e_ph = m_ph; e_x = 0; e_t = 0;
    e_pas = (!d && !(m_ph == 0 && m_sc)) ? 1 : 0;
    n_ph = (m_ph + 1) % 4; n_sc = m_sc; n_idl = m_idl; n_code = m_code;
    if (flush) begin
      n_ph = 0; n_sc = 0; n_idl = susp ? 3 : 0;
    end else if (m_idl > 0) begin
      n_ph = m_ph; n_idl = m_idl - 1;
    end else if (arr && m_sc && m_ph >= 2) begin
      n_ph = 0; n_sc = 0; n_idl = 4 - m_ph;
    end else begin
      cancel = arr && m_sc;
      if (cancel) begin e_ph = 0; n_sc = 0; end
      act = d || (m_sc && !cancel);
      if (act && !rdy) n_ph = e_ph;
      else begin
        n_ph = (e_ph + 1) % 4;
        if (act && e_ph == 0) n_code = d ? 0 : 1;
        if (act && e_ph == 2) begin e_x = 1; e_t = d ? int'(req) : 8; end
        if (e_ph == 2) n_sc = (pf_en && lvl < QDEPTH) ? 1 : 0;
      end
    end
    m_ph = n_ph; m_sc = n_sc; m_idl = n_idl; m_code = n_code; m_prev = d;
  endtask

  task automatic compare(input string tag);
    checks++;
    if (phase !== 2'(e_ph) || xfer !== 1'(e_x) || xtype !== 7'(e_t) ||
        code !== 1'(m_code) || passive !== 1'(e_pas)) begin
      fails++;
      $display("FAIL %s ph=%0d/%0d x=%0b/%0d t=%0d/%0d code=%0b/%0d pas=%0b/%0d",
               tag, phase, e_ph, xfer, e_x, xtype, e_t, code, m_code, passive, e_pas);
    end
  endtask

  // called at negedge with inputs already driven
  int saved_code;
  task automatic step(input string tag);
    saved_code = m_code;
    model_clock();
    #8;
    begin
      int nc;
      nc = m_code; m_code = saved_code;
      compare(tag);
      m_code = nc;
    end
    @(negedge clk);
  endtask

  task automatic do_req(input logic [6:0] t);
    string tag;
    tag = !m_sc ? "R10" : (m_ph < 2 ? "R5" : "R6");
    req = t;
    for (int i = 0; i < 24; i++) begin
      step(tag);
      if (e_x) break;
    end
    req = '0;
  endtask

  task automatic check_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check_val("R1", int'(phase), 0);
    check_val("R1", int'(xfer), 0);
    check_val("R1", int'(passive), 0);
    rst_n = 1'b1;
    step("R1");
    repeat (12) step("R2");
    repeat (4) step("R3");
    // full queue stops prefetch at the next T3
    lvl = LVL_W'(QDEPTH);
    repeat (8) step("R4");
    repeat (4) step("R8");
    lvl = LVL_W'(2);
    repeat (8) step("R4");
    // data requests at every phase while a fetch is scheduled
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 8 && !(m_sc && m_ph == k && m_idl == 0); j++) step("R2");
      do_req(7'h20);
    end
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 8 && !(m_sc && m_ph == k && m_idl == 0); j++) step("R2");
      do_req(k[0] ? 7'h11 : 7'h40);
    end
    // T3 abort timing: arrival to strobe is 3 idle + 3 phases
    for (int j = 0; j < 8 && !(m_sc && m_ph == 2 && m_idl == 0); j++) step("R2");
    begin
      int n;
      n = 0;
      req = 7'h25;
      for (int i = 0; i < 24; i++) begin
        n++;
        step("R6");
        if (e_x) break;
      end
      req = '0;
      check_val("R6", n, 6);
    end
    // ready low with active bus
    repeat (2) step("R2");
    rdy = 1'b0;
    repeat (3) step("R7");
    rdy = 1'b1;
    repeat (4) step("R7");
    rdy = 1'b0; req = 7'h21;
    repeat (3) step("R7");
    rdy = 1'b1;
    for (int i = 0; i < 10; i++) begin step("R7"); if (e_x) break; end
    req = '0;
    // bus idle: ready ignored
    pf_en = 1'b0;
    repeat (8) step("R4");
    rdy = 1'b0;
    repeat (6) step("R7");
    rdy = 1'b1;
    for (int k = 0; k < 4; k++) begin
      repeat (k + 1) step("R8");
      do_req(7'h13);
    end
    // flushes
    pf_en = 1'b1;
    repeat (6) step("R2");
    flush = 1'b1;
    step("R9");
    flush = 1'b0;
    repeat (8) step("R9");
    flush = 1'b1; susp = 1'b1;
    step("R9");
    flush = 1'b0; susp = 1'b0;
    repeat (10) step("R9");
    flush = 1'b1; req = 7'h20;
    step("R9");
    flush = 1'b0;
    for (int i = 0; i < 10; i++) begin step("R9"); if (e_x) break; end
    req = '0;
    repeat (8) step("R2");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule